// File: doc/BRIEF.md
# Lockable System Control Register Block

This block is the control register file of a single-CPU subsystem. It sits on a simple APB-style slave port: select, enable, write strobe, a 12-bit byte address and 32-bit data. It drives three signals into the core.

- A boot-hold output keeps the CPU waiting after reset. Software can only release it, and only a reset arms it again.
- A vector base output carries the initial secure vector table address. That register locks itself once software sets its lock bit.
- A software reset request pulse goes to the reset controller.

The block also holds several other registers:

- Debug authentication status, changed through separate set and clear registers.
- An NMI enable bit.
- A power control register that gates writes to itself through its own unlock bit.
- Four power-domain sense registers.
- Plain storage for clock configuration, reset syndrome, reset mask and a general retention register.

Integration parameters set the boot-hold and vector reset values. Only word-aligned offsets are decoded. Every other offset is reserved.

Register map. The lock, hold and NMI bits sit at bit 0.

- Debug status: 0x000. Debug set: 0x004. Debug clear: 0x008.
- Clock configuration 0/1 and clock force: 0x010, 0x014, 0x018.
- Reset syndrome: 0x100. Reset mask: 0x104. Software reset: 0x108. Retention: 0x10C.
- Vector address: 0x110. CPU hold: 0x120. NMI enable: 0x124.
- Power control: 0x1FC.
- Power-domain sense: 0x200, 0x204, 0x214, 0x218.

Top module: `sysctl_regs`

## Requirements
- R1: Reset state:
  - `cpu_hold` equals HOLD_RST and the hold register reads HOLD_RST in bit 0.
  - `vector_base` equals VTOR_RST with bits [6:0] cleared, and the vector register's lock bit (bit 0) is 0.
  - The power control register reads 0x00000001, so its unlock bit is 1.
  - Every other register reads 0.
- R2: CPU hold register at 0x120:
  - Only bit 0 is implemented; bits [31:1] read 0.
  - A write with bit 0 = 0 clears the hold, and `cpu_hold` falls.
  - A write with bit 0 = 1 never sets the hold again once it has been cleared.
- R3: Vector address register at 0x110:
  - Bits [31:7] hold the address, bit 0 is LOCK, and bits [6:1] read 0.
  - `vector_base` is bits [31:7] followed by seven zero bits.
  - Once LOCK reads 1, every write to the register is ignored until reset.
- R4: Power control register at 0x1FC:
  - Bit 0 is UNLOCK. While it reads 1, a write stores all 32 bits.
  - Once a write leaves UNLOCK at 0, every later write is ignored until reset.
- R5: The storage registers read back the last 32-bit value written to them. They sit at 0x010, 0x014, 0x018, 0x100, 0x104, 0x10C, 0x200, 0x204, 0x214 and 0x218.
- R6: Reserved offsets read 0 and ignore writes. These are every offset not listed here, including 0x118, 0x208, 0x20C, 0x210 and all unaligned addresses.
- R7: Debug authentication:
  - Writing 1s to 0x004 sets those bits of the DBG_BITS-wide status at 0x000.
  - Writing 1s to 0x008 clears them.
  - 0x000 ignores writes, and 0x004 and 0x008 read 0.
- R8: A write to 0x108 with bit 0 = 1 raises `swrst_req` for exactly one cycle, starting the cycle after the access phase. 0x108 reads 0.
- R9: NMI enable at 0x124 implements bit 0 only; bits [31:1] read 0.
- R10: A write takes effect only in the access phase (`psel`, `penable` and `pwrite` all high). A setup phase alone changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from `paddr` |
| cpu_hold | output | 1 | Holds the CPU in wait while high |
| vector_base | output | 32 | Initial secure vector table address |
| swrst_req | output | 1 | One-cycle software reset request |

## Verification
The assertions assume that bus inputs change only between clock edges. They also assume that an access phase always follows a setup phase to the same address. The bench drives every transfer in that two-phase order from the falling edge. It issues a bare setup phase only where that is the point of the test.

The reserved-read property assumes that `prdata` is looked at only while `psel` is high. It then relies on that select. The bench keeps `paddr` stable across each whole transfer.

// File: rtl/sysctl_pkg.sv
// Package: shared register identifiers, offsets and decode helpers for the
// system control block. Assumes word-aligned byte offsets in a 4 KiB window.
package sysctl_pkg;

    localparam int AW      = 12;
    localparam int DW      = 32;
    localparam int STORE_N = 10;

    // Storage registers occupy the first STORE_N codes so the code is the index.
    typedef enum logic [4:0] {
        ID_CLK0, ID_CLK1, ID_CLKF, ID_RSTSYN, ID_RSTMSK, ID_GRET,
        ID_PD0, ID_PD1, ID_PD2, ID_PD3,
        ID_DBGSTAT, ID_DBGSET, ID_DBGCLR, ID_SWRST,
        ID_VTOR, ID_HOLD, ID_NMI, ID_PWR, ID_NONE
    } reg_id_e;

    // Map a byte offset to a register identifier; anything else is reserved.
    function automatic reg_id_e decode_off(input logic [AW-1:0] a);
        case (a)
            12'h000: decode_off = ID_DBGSTAT;
            12'h004: decode_off = ID_DBGSET;
            12'h008: decode_off = ID_DBGCLR;
            12'h010: decode_off = ID_CLK0;
            12'h014: decode_off = ID_CLK1;
            12'h018: decode_off = ID_CLKF;
            12'h100: decode_off = ID_RSTSYN;
            12'h104: decode_off = ID_RSTMSK;
            12'h108: decode_off = ID_SWRST;
            12'h10C: decode_off = ID_GRET;
            12'h110: decode_off = ID_VTOR;
            12'h120: decode_off = ID_HOLD;
            12'h124: decode_off = ID_NMI;
            12'h1FC: decode_off = ID_PWR;
            12'h200: decode_off = ID_PD0;
            12'h204: decode_off = ID_PD1;
            12'h214: decode_off = ID_PD2;
            12'h218: decode_off = ID_PD3;
            default: decode_off = ID_NONE;
        endcase
    endfunction

    function automatic logic is_store(input reg_id_e id);
        return 32'(id) < STORE_N;
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
// Address decoder: turns the bus address into a register identifier and a
// hit flag. Purely combinational; assumes aligned offsets as listed in the package.
module sysctl_decode
    import sysctl_pkg::*;
(
    input  logic [AW-1:0] addr,
    output reg_id_e       id,
    output logic          hit
);
    // Decode the offset and flag whether any register answers.
    always_comb begin
        id  = decode_off(addr);
        hit = (id != ID_NONE);
    end
endmodule

// File: rtl/sysctl_lockreg.sv
// Lockable register: stores masked write data unless its own lock bit is in
// the locking state. LOCK_WHEN selects whether 1 or 0 at LOCK_BIT locks.
// Assumes RST leaves the register unlocked if a writable start is wanted.
module sysctl_lockreg #(
    parameter int          W         = 32,
    parameter logic [W-1:0] RST      = '0,
    parameter logic [W-1:0] MASK     = '1,
    parameter int          LOCK_BIT  = 0,
    parameter logic        LOCK_WHEN = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q,
    output logic         locked
);
    // Lock state follows the stored lock bit.
    always_comb locked = (q[LOCK_BIT] == LOCK_WHEN);

    // Capture masked write data while not locked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= RST & MASK;
        else if (we && !locked)
            q <= wdata & MASK;
    end
endmodule

// File: rtl/sysctl_store.sv
// Bank of N plain read-as-written registers, each with its own write enable.
// Assumes at most one enable is high per cycle (one bus write at a time).
module sysctl_store #(
    parameter int N = 10,
    parameter int W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        we,
    input  logic [W-1:0]        wdata,
    output logic [N-1:0][W-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_reg
        // Hold one storage word, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= '0;
            else if (we[i])
                q[i] <= wdata;
        end
    end
endmodule

// File: rtl/sysctl_dbgauth.sv
// Debug authentication status with write-one-to-set and write-one-to-clear
// ports; clear dominates when both touch a bit in the same cycle.
module sysctl_dbgauth #(
    parameter int B = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [B-1:0] set_bits,
    input  logic [B-1:0] clr_bits,
    output logic [B-1:0] status
);
    // Apply set then clear to the status vector.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= '0;
        else
            status <= (status | set_bits) & ~clr_bits;
    end
endmodule

// File: rtl/sysctl_regs.sv
// System control register block for a single-CPU subsystem on an APB-style
// port. Writes commit on the access phase; reads are combinational from paddr.
// Assumes DBG_BITS < 32 and that only aligned offsets are used by software.
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter logic          HOLD_RST = 1'b1,
    parameter logic [DW-1:0] VTOR_RST = 32'h1000_0000,
    parameter int            DBG_BITS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [AW-1:0] paddr,
    input  logic [DW-1:0] pwdata,
    output logic [DW-1:0] prdata,
    output logic          cpu_hold,
    output logic [DW-1:0] vector_base,
    output logic          swrst_req
);
    localparam logic [DW-1:0] VTOR_MASK = 32'hFFFF_FF81;
    localparam logic [DW-1:0] PWR_RST   = 32'h0000_0001;

    reg_id_e                      id;
    logic                         hit;
    logic                         wr;
    logic [STORE_N-1:0]           st_we;
    logic [STORE_N-1:0][DW-1:0]   st_q;
    logic [DBG_BITS-1:0]          dbg_q, dbg_set, dbg_clr;
    logic [DW-1:0]                vtor_q, pwr_q;
    logic                         vtor_locked, pwr_locked;
    logic                         nmi_q;

    sysctl_decode u_dec (.addr(paddr), .id(id), .hit(hit));

    // Qualify a bus write to the access phase.
    always_comb wr = psel && penable && pwrite;

    // Route the write strobe to the addressed storage register.
    always_comb begin
        st_we = '0;
        if (wr && is_store(id))
            st_we[4'(id)] = 1'b1;
    end

    sysctl_store #(.N(STORE_N), .W(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .we(st_we), .wdata(pwdata), .q(st_q)
    );

    // Form set and clear vectors for the debug status.
    always_comb begin
        dbg_set = (wr && id == ID_DBGSET) ? pwdata[DBG_BITS-1:0] : '0;
        dbg_clr = (wr && id == ID_DBGCLR) ? pwdata[DBG_BITS-1:0] : '0;
    end

    sysctl_dbgauth #(.B(DBG_BITS)) u_dbg (
        .clk(clk), .rst_n(rst_n), .set_bits(dbg_set), .clr_bits(dbg_clr),
        .status(dbg_q)
    );

    sysctl_lockreg #(
        .W(DW), .RST(VTOR_RST & 32'hFFFF_FF80), .MASK(VTOR_MASK),
        .LOCK_BIT(0), .LOCK_WHEN(1'b1)
    ) u_vtor (
        .clk(clk), .rst_n(rst_n), .we(wr && id == ID_VTOR), .wdata(pwdata),
        .q(vtor_q), .locked(vtor_locked)
    );

    sysctl_lockreg #(
        .W(DW), .RST(PWR_RST), .MASK('1), .LOCK_BIT(0), .LOCK_WHEN(1'b0)
    ) u_pwr (
        .clk(clk), .rst_n(rst_n), .we(wr && id == ID_PWR), .wdata(pwdata),
        .q(pwr_q), .locked(pwr_locked)
    );

    // CPU hold: only ever released at runtime, re-armed by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cpu_hold <= HOLD_RST;
        else if (wr && id == ID_HOLD && !pwdata[0])
            cpu_hold <= 1'b0;
    end

    // NMI enable bit and one-cycle software reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_q     <= 1'b0;
            swrst_req <= 1'b0;
        end else begin
            if (wr && id == ID_NMI)
                nmi_q <= pwdata[0];
            swrst_req <= wr && (id == ID_SWRST) && pwdata[0];
        end
    end

    // Drive the vector base with the address field only.
    always_comb vector_base = {vtor_q[DW-1:7], 7'b0};

    // Read multiplexer; reserved and write-only offsets return zero.
    always_comb begin
        if (is_store(id))
            prdata = st_q[4'(id)];
        else begin
            case (id)
                ID_DBGSTAT: prdata = DW'(dbg_q);
                ID_VTOR:    prdata = vtor_q;
                ID_HOLD:    prdata = {31'b0, cpu_hold};
                ID_NMI:     prdata = {31'b0, nmi_q};
                ID_PWR:     prdata = pwr_q;
                default:    prdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/sysctl_regs_chk.sv
// Checker for sysctl_regs: lock stickiness, one-way hold release, pulse width
// and reserved-read behaviour. Attached by the bind below.
module sysctl_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        psel,
    input logic        hit,
    input logic [31:0] prdata,
    input logic        cpu_hold,
    input logic [31:0] vector_base,
    input logic        vtor_locked,
    input logic        pwr_locked,
    input logic [31:0] pwr_q,
    input logic        swrst_req
);
    a_r2_hold_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_hold |=> !cpu_hold);

    a_r3_vtor_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        vtor_locked |=> vtor_locked && $stable(vector_base));

    a_r4_pwr_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_locked |=> pwr_locked && $stable(pwr_q));

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        swrst_req |=> !swrst_req);

    a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !hit) |-> (prdata == 32'h0));
endmodule

bind sysctl_regs sysctl_regs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .psel(psel), .hit(hit), .prdata(prdata),
    .cpu_hold(cpu_hold), .vector_base(vector_base), .vtor_locked(vtor_locked),
    .pwr_locked(pwr_locked), .pwr_q(pwr_q), .swrst_req(swrst_req)
);

// File: tb/sysctl_regs_test.sv
// Bench: directed lock and pulse tests, then a full sweep of every word
// offset against a bench-side model built from the requirements.
module sysctl_regs_test;
    localparam logic [31:0] VRST = 32'h1000_0000;
    localparam int          DB   = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata, vector_base;
    logic        cpu_hold, swrst_req;

    int n_chk = 0, n_fail = 0;

    // Bench model state.
    logic [31:0] m_store [0:1023];
    logic [DB-1:0] m_dbg;
    logic [31:0] m_vtor, m_pwr;
    logic        m_hold, m_nmi;

    sysctl_regs #(.HOLD_RST(1'b1), .VTOR_RST(VRST), .DBG_BITS(DB)) uut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .cpu_hold(cpu_hold), .vector_base(vector_base), .swrst_req(swrst_req)
    );

    always #5 clk = ~clk;

    function automatic logic is_st(input logic [11:0] a);
        case (a)
            12'h010, 12'h014, 12'h018, 12'h100, 12'h104, 12'h10C,
            12'h200, 12'h204, 12'h214, 12'h218: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string req_of(input logic [11:0] a);
        if (is_st(a)) return "R5";
        case (a)
            12'h000, 12'h004, 12'h008: return "R7";
            12'h108: return "R8";
            12'h110: return "R3";
            12'h120: return "R2";
            12'h124: return "R9";
            12'h1FC: return "R4";
            default: return "R6";
        endcase
    endfunction

    function automatic logic [31:0] exp_rd(input logic [11:0] a);
        if (is_st(a)) return m_store[a[11:2]];
        case (a)
            12'h000: return {24'b0, m_dbg};
            12'h110: return m_vtor;
            12'h120: return {31'b0, m_hold};
            12'h124: return {31'b0, m_nmi};
            12'h1FC: return m_pwr;
            default: return 32'h0;
        endcase
    endfunction

    task automatic mdl_write(input logic [11:0] a, input logic [31:0] d);
        if (is_st(a)) m_store[a[11:2]] = d;
        else case (a)
            12'h004: m_dbg = m_dbg | d[DB-1:0];
            12'h008: m_dbg = m_dbg & ~d[DB-1:0];
            12'h110: if (!m_vtor[0]) m_vtor = d & 32'hFFFF_FF81;
            12'h120: m_hold = m_hold & d[0];
            12'h124: m_nmi = d[0];
            12'h1FC: if (m_pwr[0]) m_pwr = d;
            default: ;
        endcase
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        mdl_write(a, d);
        #1;
    endtask

    task automatic apb_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] a);
        logic [31:0] d;
        apb_read(a, d);
        chk(req_of(a), d, exp_rd(a));
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) m_store[i] = '0;
        m_dbg = '0; m_vtor = VRST & 32'hFFFF_FF80; m_pwr = 32'h1;
        m_hold = 1'b1; m_nmi = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset outputs and every offset read in reset state.
        chk("R1", {31'b0, cpu_hold}, 32'h1);
        chk("R1", vector_base, VRST);
        chk("R1", {31'b0, swrst_req}, 32'h0);
        for (int i = 0; i < 1024; i++) rd_chk(12'(i * 4));

        // R2: writing 1 keeps hold, 0 releases, 1 again cannot re-hold.
        apb_write(12'h120, 32'hFFFF_FFFF);
        chk("R2", {31'b0, cpu_hold}, 32'h1);
        rd_chk(12'h120);
        apb_write(12'h120, 32'hFFFF_FFFE);
        chk("R2", {31'b0, cpu_hold}, 32'h0);
        apb_write(12'h120, 32'h0000_0001);
        chk("R2", {31'b0, cpu_hold}, 32'h0);
        rd_chk(12'h120);

        // R3: unlocked write, lock, then ignored write.
        apb_write(12'h110, 32'h2000_00FE);
        chk("R3", vector_base, 32'h2000_0080);
        rd_chk(12'h110);
        apb_write(12'h110, 32'h3000_0101);
        chk("R3", vector_base, 32'h3000_0100);
        apb_write(12'h110, 32'h4000_0000);
        chk("R3", vector_base, 32'h3000_0100);
        rd_chk(12'h110);

        // R4: writes accepted while unlocked, then locked out.
        apb_write(12'h1FC, 32'hDEAD_BEEF);
        rd_chk(12'h1FC);
        apb_write(12'h1FC, 32'h1234_5670);
        rd_chk(12'h1FC);
        apb_write(12'h1FC, 32'hFFFF_FFFF);
        chk("R4", exp_rd(12'h1FC), 32'h1234_5670);
        rd_chk(12'h1FC);

        // R7: set, clear, write to status ignored, set/clear read zero.
        apb_write(12'h004, 32'h0000_00F0);
        apb_write(12'h008, 32'h0000_0030);
        apb_write(12'h000, 32'h0000_0000);
        chk("R7", exp_rd(12'h000), 32'h0000_00C0);
        rd_chk(12'h000); rd_chk(12'h004); rd_chk(12'h008);

        // R8: one-cycle reset request, register reads zero.
        apb_write(12'h108, 32'h0000_0001);
        chk("R8", {31'b0, swrst_req}, 32'h1);
        @(negedge clk); #1;
        chk("R8", {31'b0, swrst_req}, 32'h0);
        apb_write(12'h108, 32'h0000_0000);
        chk("R8", {31'b0, swrst_req}, 32'h0);
        rd_chk(12'h108);

        // R9: NMI enable keeps only bit 0.
        apb_write(12'h124, 32'hFFFF_FFFF);
        rd_chk(12'h124);

        // R10: setup phase alone does not write.
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = 12'h10C; pwdata = 32'hCAFE_F00D;
        @(negedge clk);
        psel = 1'b0; pwrite = 1'b0;
        begin
            logic [31:0] d;
            apb_read(12'h10C, d);
            chk("R10", d, 32'h0);
        end

        // R5/R6 sweep: write a distinct pattern to every offset, read all back.
        for (int i = 0; i < 1024; i++)
            apb_write(12'(i * 4), 32'h5A3C_0000 ^ (32'(i) * 32'h0001_0101));
        for (int i = 0; i < 1024; i++) rd_chk(12'(i * 4));
        chk("R3", vector_base, m_vtor & 32'hFFFF_FF80);
        chk("R2", {31'b0, cpu_hold}, {31'b0, m_hold});

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule